// File: doc/BRIEF.md
# Transceiver Power-State Sequencer

This block steps a radio transceiver through its operating states. From a cold start it waits for the supply and oscillator to settle, brings the core out of reset on the crystal clock divided by two, enables the PLL and, once the PLL reports lock, settles in IDLE on the PLL clock. From IDLE the host can start a transmit or a receive, either at once or deferred until a programmed time. It can also enter a low-power snooze that later wakes into receive, or force the core back to INIT on the plain crystal clock.

When a transmit or receive finishes, a per-direction auto-sleep bit can send the device to SLEEP or DEEPSLEEP instead of IDLE. This happens only when no interrupt is pending. Before sleeping, the configuration is copied into the always-on memory (SAVE state). On wake the copy is brought back (RESTORE state) only if the restore bit is set. Wake sources are a chip-select held low or a wake pin held high for a set number of cycles, each with its own enable bit. In SLEEP only, the sleep timer can also wake the device when its enable bit is set. All durations are parameters counted in clock cycles.

States: OFF, WAKEUP, RESTORE, INIT, IDLE, TX, RX, SNOOZE, SAVE, SLEEP, DEEPSLEEP. Transitions are:

- OFF→WAKEUP on power good.
- WAKEUP→RESTORE or WAKEUP→INIT when the settle time ends.
- RESTORE→INIT when the copy ends.
- INIT→IDLE on lock.
- IDLE→INIT on force.
- IDLE→RX after snooze.
- IDLE→TX and IDLE→RX on a start request or a deferred start.
- IDLE→SNOOZE on a snooze request.
- TX→IDLE or TX→SAVE on transmit done.
- RX→IDLE or RX→SAVE on receive done.
- SNOOZE→INIT when the count ends.
- SAVE→SLEEP or SAVE→DEEPSLEEP when the copy ends.
- SLEEP→WAKEUP and DEEPSLEEP→WAKEUP on a qualified wake.
- Any state→OFF on loss of power good.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset `state_o` is OFF. The codes are OFF=0, WAKEUP=1, INIT=2, IDLE=3, TX=4, RX=5, SNOOZE=6, SLEEP=7, DEEPSLEEP=8, SAVE=9 and RESTORE=10. One cycle after `pwr_good` rises the state is WAKEUP. It stays there exactly WAKE_CYC cycles with `core_rst_n` low, and `core_rst_n` is high once WAKEUP ends.
- R2: In INIT, `pll_en` is 1 and `clk_sel` is 1. The `clk_sel` codes are 0=off, 1=crystal/2, 2=crystal, 3=PLL. INIT stays put while `pll_lock` is 0 and moves to IDLE one cycle after lock. In IDLE `clk_sel` is 3.
- R3: In IDLE, an immediate `tx_start` enters TX with only `tx_en` set, and an immediate `rx_start` enters RX with only `rx_en` set. When both arrive together, TX wins. `tx_en` and `rx_en` are never both 1.
- R4: On `tx_done` (or `rx_done`), the state becomes SAVE if `auto_sleep_tx` (or `auto_sleep_rx`) is set and `irq_pend` is 0. Otherwise it becomes IDLE.
- R5: A start request made with `dly_mode` set keeps the state in IDLE until `dly_hit` is seen. TX or RX follows one cycle after that.
- R6: DEEPSLEEP leaves only for WAKEUP. This happens once chip-select has been held low (`wake_cs_en` set) or the wake pin held high (`wake_pin_en` set) for HOLD_CYC consecutive cycles, and WAKEUP appears one cycle later. A source whose enable bit is clear has no effect, and neither does the sleep timer.
- R7: SLEEP moves to WAKEUP one cycle after `sleep_tmr_exp` when `tmr_wake_en` is 1. With `tmr_wake_en` at 0 the timer has no effect.
- R8: SAVE lasts exactly COPY_CYC cycles with `aon_save` high, then enters DEEPSLEEP if `sleep_deep` was set at entry and SLEEP otherwise. A wake from sleep passes through RESTORE for COPY_CYC cycles with `aon_restore` high only when `restore_en` is 1; otherwise WAKEUP goes straight to INIT.
- R9: A wake qualifier that completes during SAVE does not shorten the copy. The sleep state is entered for one cycle and WAKEUP follows.
- R10: Releasing a wake qualifier before HOLD_CYC cycles clears its hold count, so a later assertion needs a full HOLD_CYC again.
- R11: `snooze_req` in IDLE enters SNOOZE, which lasts 2×SNOOZE_CYC cycles (SNOOZE_CYC crystal/2 periods). The state then goes INIT, then IDLE, then RX with no further request.
- R12: `force_init` in IDLE returns to INIT with `clk_sel`=2 and `pll_en`=0. The state stays in INIT while `force_init` is held.
- R13: When `pwr_good` is 0, the next state is OFF, with `clk_sel`=0 and `core_rst_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply above threshold |
| pll_lock | input | 1 | PLL lock report |
| tx_start | input | 1 | Transmit request |
| rx_start | input | 1 | Receive request |
| dly_mode | input | 1 | Request is deferred until `dly_hit` |
| dly_hit | input | 1 | Programmed start time reached |
| tx_done | input | 1 | Transmit finished |
| rx_done | input | 1 | Receive finished |
| snooze_req | input | 1 | Enter snooze from IDLE |
| wake_pin | input | 1 | Wake pin level |
| cs_n | input | 1 | Chip select, active low |
| sleep_tmr_exp | input | 1 | Sleep counter expired |
| irq_pend | input | 1 | Interrupt pending |
| auto_sleep_tx | input | 1 | Sleep after transmit |
| auto_sleep_rx | input | 1 | Sleep after receive |
| sleep_deep | input | 1 | Auto-sleep target is DEEPSLEEP |
| wake_cs_en | input | 1 | Chip-select wake enable |
| wake_pin_en | input | 1 | Wake-pin wake enable |
| tmr_wake_en | input | 1 | Sleep-timer wake enable |
| restore_en | input | 1 | Restore configuration on wake |
| force_init | input | 1 | Return to INIT on crystal clock |
| state_o | output | 4 | Current state code |
| clk_sel | output | 2 | Clock source select |
| core_rst_n | output | 1 | Digital core reset, active low |
| pll_en | output | 1 | PLL enable |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| aon_save | output | 1 | Copy to always-on memory in progress |
| aon_restore | output | 1 | Copy from always-on memory in progress |

## Verification
The two functions that can land in the same cycle are completion of a wake qualifier and the save copy into always-on memory. To provoke the overlap, the bench asserts chip-select low in the first SAVE cycle with a hold time shorter than the copy. The result is judged by the copy running its full COPY_CYC cycles, exactly one SLEEP cycle following it, and WAKEUP after that. A second overlap tests both start requests arriving in one IDLE cycle, where TX must be chosen and the receive path must stay off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF     = 4'd0,
        ST_WAKEUP  = 4'd1,
        ST_INIT    = 4'd2,
        ST_IDLE    = 4'd3,
        ST_TX      = 4'd4,
        ST_RX      = 4'd5,
        ST_SNOOZE  = 4'd6,
        ST_SLEEP   = 4'd7,
        ST_DEEP    = 4'd8,
        ST_SAVE    = 4'd9,
        ST_RESTORE = 4'd10
    } pwr_state_e;

    typedef enum logic [1:0] {
        CLK_NONE  = 2'd0,
        CLK_XDIV2 = 2'd1,
        CLK_XTAL  = 2'd2,
        CLK_PLL   = 2'd3
    } clk_src_e;

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
    parameter int HOLD_CYC = 3,
    localparam int HW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic raw,
    output logic qual
);
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!enable || !raw) begin
            hold_q <= '0;
        end else if (hold_q != HW'(HOLD_CYC)) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    assign qual = (hold_q == HW'(HOLD_CYC));
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          half_rate,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic          ph_q;
    logic          tick;

    assign tick = half_rate ? ph_q : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = tick && ((cnt_q + 1'b1) == limit);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int WAKE_CYC   = 8,
    parameter int COPY_CYC   = 6,
    parameter int HOLD_CYC   = 3,
    parameter int SNOOZE_CYC = 5,
    localparam int MAXC = (WAKE_CYC > COPY_CYC) ?
                          ((WAKE_CYC > SNOOZE_CYC) ? WAKE_CYC : SNOOZE_CYC) :
                          ((COPY_CYC > SNOOZE_CYC) ? COPY_CYC : SNOOZE_CYC),
    localparam int CW = $clog2(MAXC + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       pll_lock,
    input  logic       tx_start,
    input  logic       rx_start,
    input  logic       dly_mode,
    input  logic       dly_hit,
    input  logic       tx_done,
    input  logic       rx_done,
    input  logic       snooze_req,
    input  logic       wake_pin,
    input  logic       cs_n,
    input  logic       sleep_tmr_exp,
    input  logic       irq_pend,
    input  logic       auto_sleep_tx,
    input  logic       auto_sleep_rx,
    input  logic       sleep_deep,
    input  logic       wake_cs_en,
    input  logic       wake_pin_en,
    input  logic       tmr_wake_en,
    input  logic       restore_en,
    input  logic       force_init,
    output logic [3:0] state_o,
    output logic [1:0] clk_sel,
    output logic       core_rst_n,
    output logic       pll_en,
    output logic       tx_en,
    output logic       rx_en,
    output logic       aon_save,
    output logic       aon_restore
);
    pwr_state_e    state_q, state_d;
    logic          restart, tmr_done;
    logic [CW-1:0] limit;
    logic          tx_pend_q, rx_pend_q, snz_rx_q, from_sleep_q, deep_q;
    logic          sleep_like;
    logic [1:0]    wake_raw, wake_en, wake_qual;
    logic          any_wake;
    logic          go_tx, go_rx;

    // duration selection per timed state
    always_comb begin
        unique case (state_q)
            ST_SAVE, ST_RESTORE: limit = CW'(COPY_CYC);
            ST_SNOOZE:           limit = CW'(SNOOZE_CYC);
            default:             limit = CW'(WAKE_CYC);
        endcase
    end

    assign restart = (state_d != state_q);

    pwr_seq_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .half_rate (state_q == ST_SNOOZE),
        .limit     (limit),
        .done      (tmr_done)
    );

    // wake qualifiers: index 0 chip select, index 1 wake pin
    assign sleep_like  = (state_q == ST_SAVE) || (state_q == ST_SLEEP) || (state_q == ST_DEEP);
    assign wake_raw[0] = ~cs_n;
    assign wake_raw[1] = wake_pin;
    assign wake_en[0]  = wake_cs_en && sleep_like;
    assign wake_en[1]  = wake_pin_en && sleep_like;

    for (genvar g = 0; g < 2; g++) begin : g_wake
        pwr_wake_filter #(.HOLD_CYC(HOLD_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (wake_en[g]),
            .raw    (wake_raw[g]),
            .qual   (wake_qual[g])
        );
    end

    assign any_wake = |wake_qual;
    assign go_tx = (tx_start && !dly_mode) || (tx_pend_q && dly_hit);
    assign go_rx = (rx_start && !dly_mode) || (rx_pend_q && dly_hit);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!pwr_good) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_WAKEUP;
                ST_WAKEUP:  if (tmr_done) state_d = (from_sleep_q && restore_en) ? ST_RESTORE : ST_INIT;
                ST_RESTORE: if (tmr_done) state_d = ST_INIT;
                ST_INIT:    if (!force_init && pll_lock) state_d = ST_IDLE;
                ST_IDLE: begin
                    if (force_init)      state_d = ST_INIT;
                    else if (snz_rx_q)   state_d = ST_RX;
                    else if (go_tx)      state_d = ST_TX;
                    else if (go_rx)      state_d = ST_RX;
                    else if (snooze_req) state_d = ST_SNOOZE;
                end
                ST_TX:      if (tx_done) state_d = (auto_sleep_tx && !irq_pend) ? ST_SAVE : ST_IDLE;
                ST_RX:      if (rx_done) state_d = (auto_sleep_rx && !irq_pend) ? ST_SAVE : ST_IDLE;
                ST_SNOOZE:  if (tmr_done) state_d = ST_INIT;
                ST_SAVE:    if (tmr_done) state_d = deep_q ? ST_DEEP : ST_SLEEP;
                ST_SLEEP:   if (any_wake || (tmr_wake_en && sleep_tmr_exp)) state_d = ST_WAKEUP;
                ST_DEEP:    if (any_wake) state_d = ST_WAKEUP;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // sequencing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pend_q    <= 1'b0;
            rx_pend_q    <= 1'b0;
            snz_rx_q     <= 1'b0;
            from_sleep_q <= 1'b0;
            deep_q       <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (tx_start && dly_mode) tx_pend_q <= 1'b1;
                if (rx_start && dly_mode) rx_pend_q <= 1'b1;
            end
            if (state_d == ST_TX || state_d == ST_OFF) tx_pend_q <= 1'b0;
            if (state_d == ST_RX || state_d == ST_OFF) rx_pend_q <= 1'b0;

            if (state_q == ST_SNOOZE && state_d == ST_INIT) snz_rx_q <= 1'b1;
            else if (state_d == ST_RX || state_d == ST_OFF) snz_rx_q <= 1'b0;

            if ((state_q == ST_SLEEP || state_q == ST_DEEP) && state_d == ST_WAKEUP)
                from_sleep_q <= 1'b1;
            else if (state_q == ST_OFF || state_d == ST_INIT)
                from_sleep_q <= 1'b0;

            if (state_d == ST_SAVE && state_q != ST_SAVE) deep_q <= sleep_deep;
        end
    end

    // outputs from the current state
    always_comb begin
        clk_sel     = CLK_NONE;
        core_rst_n  = 1'b1;
        pll_en      = 1'b0;
        tx_en       = 1'b0;
        rx_en       = 1'b0;
        aon_save    = 1'b0;
        aon_restore = 1'b0;
        unique case (state_q)
            ST_OFF:     core_rst_n = 1'b0;
            ST_WAKEUP: begin
                core_rst_n = 1'b0;
                clk_sel    = CLK_XDIV2;
            end
            ST_RESTORE: begin
                clk_sel     = CLK_XDIV2;
                aon_restore = 1'b1;
            end
            ST_INIT: begin
                clk_sel = force_init ? CLK_XTAL : CLK_XDIV2;
                pll_en  = !force_init;
            end
            ST_IDLE: begin
                clk_sel = CLK_PLL;
                pll_en  = 1'b1;
            end
            ST_TX: begin
                clk_sel = CLK_PLL;
                pll_en  = 1'b1;
                tx_en   = 1'b1;
            end
            ST_RX: begin
                clk_sel = CLK_PLL;
                pll_en  = 1'b1;
                rx_en   = 1'b1;
            end
            ST_SNOOZE:  clk_sel = CLK_XDIV2;
            ST_SAVE: begin
                clk_sel  = CLK_XDIV2;
                aon_save = 1'b1;
            end
            ST_SLEEP, ST_DEEP: clk_sel = CLK_NONE;
            default:    core_rst_n = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       pll_lock,
    input logic [3:0] state_o,
    input logic       core_rst_n,
    input logic       tx_en,
    input logic       rx_en
);
    assert_path_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en));

    assert_tx_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(state_o) == ST_IDLE));

    assert_lock_before_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && $past(state_o) == ST_INIT) |-> $past(pll_lock));

    assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> ($past(state_o) == ST_WAKEUP));

    assert_deep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DEEP) |=> (state_o == ST_DEEP || state_o == ST_WAKEUP || state_o == ST_OFF));

    assert_save_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SAVE) |=> (state_o == ST_SAVE || state_o == ST_SLEEP ||
                                  state_o == ST_DEEP || state_o == ST_OFF));

    assert_power_loss_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state_o == ST_OFF));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .pll_lock   (pll_lock),
    .state_o    (state_o),
    .core_rst_n (core_rst_n),
    .tx_en      (tx_en),
    .rx_en      (rx_en)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    localparam int WAKE_CYC = 8, COPY_CYC = 6, HOLD_CYC = 3, SNOOZE_CYC = 5;
    localparam logic [3:0] S_OFF = 0, S_WAKE = 1, S_INIT = 2, S_IDLE = 3, S_TX = 4,
        S_RX = 5, S_SNZ = 6, S_SLP = 7, S_DEEP = 8, S_SAVE = 9, S_RST = 10;

    // {is_tx, auto_tx, auto_rx, irq, expect_save}
    localparam logic [4:0] VEC [0:7] = '{
        5'b1_1_0_0_1, 5'b1_1_0_1_0, 5'b1_0_1_0_0, 5'b0_0_1_0_1,
        5'b0_0_1_1_0, 5'b0_1_0_0_0, 5'b1_0_0_0_0, 5'b0_1_1_0_1 };

    logic clk = 0, rst_n = 0;
    logic pwr_good = 0, pll_lock = 0, tx_start = 0, rx_start = 0, dly_mode = 0, dly_hit = 0;
    logic tx_done = 0, rx_done = 0, snooze_req = 0, wake_pin = 0, cs_n = 1, sleep_tmr_exp = 0;
    logic irq_pend = 0, auto_sleep_tx = 0, auto_sleep_rx = 0, sleep_deep = 0;
    logic wake_cs_en = 0, wake_pin_en = 0, tmr_wake_en = 0, restore_en = 0, force_init = 0;
    logic [3:0] state_o;
    logic [1:0] clk_sel;
    logic core_rst_n, pll_en, tx_en, rx_en, aon_save, aon_restore;
    int n_chk = 0, n_fail = 0;
    int n;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(.WAKE_CYC(WAKE_CYC), .COPY_CYC(COPY_CYC), .HOLD_CYC(HOLD_CYC),
                   .SNOOZE_CYC(SNOOZE_CYC)) u_dut (.*);

    task automatic step(); @(posedge clk); #1; endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_st(input logic [3:0] exp, input string tag);
        chk(state_o == exp, tag, state_o, exp);
    endtask

    task automatic count_while(input logic [3:0] s, output int c);
        c = 0;
        while (state_o == s && c < 1000) begin step(); c++; end
    endtask

    task automatic wait_st(input logic [3:0] s);
        for (int i = 0; i < 300 && state_o != s; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #12 rst_n = 1;
        step();
        // R1 reset state
        chk_st(S_OFF, "R1 reset state");
        chk(core_rst_n == 0 && clk_sel == 0, "R1 reset outputs", {clk_sel, core_rst_n}, 0);
        pwr_good = 1; step();
        chk_st(S_WAKE, "R1 wakeup entry");
        chk(core_rst_n == 0, "R1 core held in reset", core_rst_n, 0);
        count_while(S_WAKE, n);
        chk(n == WAKE_CYC, "R1 wakeup length", n, WAKE_CYC);
        chk(core_rst_n == 1, "R1 reset released", core_rst_n, 1);

        // R2 INIT waits for lock
        repeat (4) step();
        chk_st(S_INIT, "R2 init waits lock");
        chk(pll_en == 1 && clk_sel == 1, "R2 init clock", {clk_sel, pll_en}, 3);
        pll_lock = 1; step();
        chk_st(S_IDLE, "R2 idle after lock");
        chk(clk_sel == 3, "R2 pll clock", clk_sel, 3);

        // R3/R4 exit routing table
        tmr_wake_en = 1; sleep_tmr_exp = 1;
        for (int i = 0; i < 8; i++) begin
            auto_sleep_tx = VEC[i][3]; auto_sleep_rx = VEC[i][2]; irq_pend = VEC[i][1];
            if (VEC[i][4]) tx_start = 1; else rx_start = 1;
            step(); tx_start = 0; rx_start = 0;
            chk_st(VEC[i][4] ? S_TX : S_RX, "R3 start");
            chk(tx_en == VEC[i][4] && rx_en == !VEC[i][4], "R3 path enable", {tx_en, rx_en}, {VEC[i][4], !VEC[i][4]});
            if (VEC[i][4]) tx_done = 1; else rx_done = 1;
            step(); tx_done = 0; rx_done = 0;
            chk_st(VEC[i][0] ? S_SAVE : S_IDLE, "R4 done routing");
            wait_st(S_IDLE);
        end
        irq_pend = 0; tmr_wake_en = 0; sleep_tmr_exp = 0;

        // R3 both starts: TX wins
        tx_start = 1; rx_start = 1; step(); tx_start = 0; rx_start = 0;
        chk_st(S_TX, "R3 tx priority");
        chk(rx_en == 0, "R3 rx stays off", rx_en, 0);
        tx_done = 1; auto_sleep_tx = 0; step(); tx_done = 0;

        // R5 deferred receive
        dly_mode = 1; rx_start = 1; step(); rx_start = 0;
        repeat (5) step();
        chk_st(S_IDLE, "R5 waits for time");
        dly_hit = 1; step(); dly_hit = 0; dly_mode = 0;
        chk_st(S_RX, "R5 enters rx");
        rx_done = 1; auto_sleep_rx = 0; step(); rx_done = 0;

        // R7/R8 sleep with timer wake
        auto_sleep_tx = 1; sleep_deep = 0; tx_start = 1; step(); tx_start = 0;
        tx_done = 1; step(); tx_done = 0;
        chk(aon_save == 1, "R8 save strobe", aon_save, 1);
        count_while(S_SAVE, n);
        chk(n == COPY_CYC, "R8 save length", n, COPY_CYC);
        chk_st(S_SLP, "R8 sleep target");
        sleep_tmr_exp = 1; repeat (4) step();
        chk_st(S_SLP, "R7 timer ignored when disabled");
        tmr_wake_en = 1; step();
        chk_st(S_WAKE, "R7 timer wake");
        tmr_wake_en = 0; sleep_tmr_exp = 0;
        count_while(S_WAKE, n);
        chk_st(S_INIT, "R8 no restore when disabled");
        wait_st(S_IDLE);

        // R6/R10 deep sleep wake qualifiers, R8 restore
        sleep_deep = 1; wake_cs_en = 1; wake_pin_en = 0; tmr_wake_en = 1; sleep_tmr_exp = 1;
        tx_start = 1; step(); tx_start = 0; tx_done = 1; step(); tx_done = 0;
        wait_st(S_DEEP);
        wake_pin = 1; repeat (8) step();
        chk_st(S_DEEP, "R6 pin and timer ignored");
        wake_pin = 0;
        cs_n = 0; repeat (HOLD_CYC - 1) step(); cs_n = 1; step();
        chk_st(S_DEEP, "R10 short hold no wake");
        cs_n = 0; repeat (HOLD_CYC) step();
        chk_st(S_DEEP, "R10 count restarted");
        step();
        chk_st(S_WAKE, "R6 cs wake after hold");
        cs_n = 1; tmr_wake_en = 0; sleep_tmr_exp = 0; restore_en = 1;
        count_while(S_WAKE, n);
        chk_st(S_RST, "R8 restore entered");
        chk(aon_restore == 1, "R8 restore strobe", aon_restore, 1);
        count_while(S_RST, n);
        chk(n == COPY_CYC, "R8 restore length", n, COPY_CYC);
        restore_en = 0;
        wait_st(S_IDLE);

        // R9 wake qualifies during save
        sleep_deep = 0; tx_start = 1; step(); tx_start = 0; tx_done = 1; step(); tx_done = 0;
        chk_st(S_SAVE, "R9 save entered");
        cs_n = 0;
        count_while(S_SAVE, n);
        chk(n == COPY_CYC, "R9 save not shortened", n, COPY_CYC);
        chk_st(S_SLP, "R9 sleep reached");
        step();
        chk_st(S_WAKE, "R9 held wake");
        cs_n = 1; wake_cs_en = 0; auto_sleep_tx = 0;
        wait_st(S_IDLE);

        // R11 snooze lands in receive
        snooze_req = 1; step(); snooze_req = 0;
        chk_st(S_SNZ, "R11 snooze entry");
        count_while(S_SNZ, n);
        chk(n == 2 * SNOOZE_CYC, "R11 snooze length", n, 2 * SNOOZE_CYC);
        chk_st(S_INIT, "R11 init after snooze");
        step(); chk_st(S_IDLE, "R11 idle");
        step(); chk_st(S_RX, "R11 auto receive");
        rx_done = 1; step(); rx_done = 0;

        // R12 forced init
        force_init = 1; step();
        chk_st(S_INIT, "R12 forced init");
        chk(clk_sel == 2 && pll_en == 0, "R12 crystal clock", {clk_sel, pll_en}, 4);
        repeat (3) step();
        chk_st(S_INIT, "R12 held in init");
        force_init = 0; step();
        chk_st(S_IDLE, "R12 release");

        // R13 power loss
        pwr_good = 0; step();
        chk_st(S_OFF, "R13 off on power loss");
        chk(clk_sel == 0 && core_rst_n == 0, "R13 outputs", {clk_sel, core_rst_n}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule